// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block models a small synchronous SRAM that accepts one command per clock with no idle cycles needed when reads and writes alternate. The command inputs are captured on the rising edge: address, read/write select, per-lane write mask and three chip selects. Read data leaves through an output register. Write data is taken from the data input on the same clock slot in which read data would appear. Because both directions use the same slot, a shared bus never needs a turnaround cycle.

A write therefore stays pending for two cycles after its command. During that time its address and mask wait in the command pipeline. A read that follows a write to the same address picks up the incoming write data lane by lane, so results always follow command order. A clock-enable input freezes every stage. An asynchronous output enable can release the data outputs at any time.

Top module: `ssram_late_write`

## Requirements
- R1: While `rstN` is low, and after it rises until the first command completes, `rdValid` and `dataOe` are 0.
- R2: A read command captured at enabled edge k has its word on `dataOut`, with `rdValid` = 1, from enabled edge k+1 until the next enabled edge. A command is a read when `chipSel` = 3'b111 and `writeEn` = 0.
- R3: A write command captured at enabled edge k takes its data from `dataIn` at enabled edge k+2. Lane i is bits [9i+8:9i], and it changes only when `byteSel[i]` = 1.
- R4: When `chipSel` is any value other than 3'b111 at an enabled edge, that cycle is a deselect. It writes nothing, it never raises `rdValid`, and it leaves stored data untouched.
- R5: Reads and writes may follow one another in any order. Every read returns the contents written by all earlier writes, including a write issued in the immediately preceding cycle, lane by lane.
- R6: An edge with `clkEn` = 0 changes nothing. The command on the inputs is dropped, every pipeline stage and the output word hold their values, and no write happens.
- R7: In the output slot belonging to a write command or a deselect, `dataOe` is 0.
- R8: `outEn` = 0 forces `dataOe` to 0 and `dataOut` to high impedance at once, without waiting for a clock.
- R9: `rdValid` is 1 exactly in the output slots of read commands, whatever the level of `outEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the command pipeline |
| clkEn | input | 1 | High to let the edge advance the pipeline |
| chipSel | input | 3 | Chip selects; all ones starts a command |
| writeEn | input | 1 | 1 = write, 0 = read |
| byteSel | input | 4 | Per-lane write mask, bit i for bits [9i+8:9i] |
| addr | input | 8 | Word address |
| dataIn | input | 36 | Write data, sampled two enabled edges after the command |
| outEn | input | 1 | Asynchronous output enable |
| dataOut | output | 36 | Read data, high impedance when not driven |
| dataOe | output | 1 | High while `dataOut` is driven |
| rdValid | output | 1 | High in the output slot of a read |

## Verification
The bench targets a read issued directly after a write to the same address, under every one of the 16 masks. A design without lane forwarding would return the stale word there, and a design with the wrong lane order would corrupt the wrong 9 bits. Random mixes with stalled edges catch a stage that moves while the clock is disabled: it would shift results one slot early or commit junk data from `dataIn`. Each of the seven partial chip-select codes is tried as a write, then read back, to expose a decoder that accepts a command when only some selects are high. Slots with `outEn` low, and write slots, must show the drivers released.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 8;
  localparam int CS_N   = 3;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  mask;
  } cmd_t;

  typedef struct packed {
    logic              adv;
    logic              rdLoad;
    logic [ADDR_W-1:0] rdAddr;
    logic              wrCommit;
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  wrMask;
    logic [LANES-1:0]  fwdMask;
    logic              outValid;
  } strobe_t;
endpackage

// File: rtl/ssram_ctrl.sv
module ssram_ctrl
  import ssram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [CS_N-1:0]   chipSel,
  input  logic              writeEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st,
  output logic              rdValid
);
  cmd_t nextCmd;
  cmd_t s1;
  cmd_t s2;
  logic s1Rd;
  logic s2Wr;
  logic addrHit;

  always_comb begin
    nextCmd.valid = &chipSel;
    nextCmd.write = writeEn;
    nextCmd.addr  = addr;
    nextCmd.mask  = byteSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= '0;
      s2 <= '0;
    end else if (clkEn) begin
      s1 <= nextCmd;
      s2 <= s1;
    end
  end

  assign s1Rd    = s1.valid && !s1.write;
  assign s2Wr    = s2.valid && s2.write;
  assign addrHit = (s1.addr == s2.addr);

  always_comb begin
    st.adv      = clkEn;
    st.rdLoad   = s1Rd;
    st.rdAddr   = s1.addr;
    st.wrCommit = s2Wr;
    st.wrAddr   = s2.addr;
    st.wrMask   = s2.mask;
    st.fwdMask  = (s1Rd && s2Wr && addrHit) ? s2.mask : '0;
    st.outValid = s2.valid && !s2.write;
  end

  assign rdValid = st.outValid;

  // R6
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(s1) && $stable(s2)));

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !(&chipSel)) |=> !s1.valid);

  // R2
  read_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && s1Rd) |=> rdValid);
endmodule

// File: rtl/ssram_dpath.sv
module ssram_dpath
  import ssram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [LANES-1:0][LANE_W-1:0] inWord;
  logic [LANES-1:0][LANE_W-1:0] rdWord;
  logic [LANES-1:0][LANE_W-1:0] outReg;

  assign inWord = dataIn;

  always_ff @(posedge clk) begin
    if (st.adv && st.wrCommit) begin
      for (int i = 0; i < LANES; i++) begin
        if (st.wrMask[i]) mem[st.wrAddr][i] <= inWord[i];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdWord[g] = st.fwdMask[g] ? inWord[g] : mem[st.rdAddr][g];
  end

  always_ff @(posedge clk) begin
    if (st.adv && st.rdLoad) outReg <= rdWord;
  end

  assign dataOe  = outEn && st.outValid;
  assign dataOut = dataOe ? outReg : {DATA_W{1'bz}};

  // R7
  write_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCommit |-> !dataOe);

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !dataOe);
endmodule

// File: rtl/ssram_late_write.sv
module ssram_late_write
  import ssram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [CS_N-1:0]   chipSel,
  input  logic              writeEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdValid
);
  strobe_t st;

  ssram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkEn   (clkEn),
    .chipSel (chipSel),
    .writeEn (writeEn),
    .byteSel (byteSel),
    .addr    (addr),
    .st      (st),
    .rdValid (rdValid)
  );

  ssram_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .dataIn  (dataIn),
    .outEn   (outEn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );
endmodule

// File: tb/sim_ssram_late_write.sv
module sim_ssram_late_write;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rstN;
  logic        clkEn;
  logic [2:0]  chipSel;
  logic        writeEn;
  logic [3:0]  byteSel;
  logic [7:0]  addr;
  logic [35:0] dataIn;
  logic        outEn;
  wire  [35:0] dataOut;
  wire         dataOe;
  wire         rdValid;

  int checks = 0;
  int fails  = 0;

  logic [35:0] refMem [256];
  logic        p1v, p1w, p2v, p2w;
  logic [35:0] p1d, p2d;
  logic [15:0] lfsr = 16'hACE1;

  ssram_late_write u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .chipSel(chipSel),
    .writeEn(writeEn), .byteSel(byteSel), .addr(addr), .dataIn(dataIn),
    .outEn(outEn), .dataOut(dataOut), .dataOe(dataOe), .rdValid(rdValid)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [35:0] patt(input int a, input int salt);
    logic [35:0] v;
    v = 36'(a * 36'h1F3D5) ^ 36'(salt * 36'h9C4A7) ^ 36'hA5C3_96E1_7;
    return v;
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a negedge; ends just after the next negedge.
  task automatic cyc(input logic en, input logic [2:0] cs, input logic we,
                     input logic [3:0] bs, input logic [7:0] a,
                     input logic [35:0] wd, input logic oe);
    logic        nv, expRd;
    logic [35:0] nd;
    clkEn   = en;
    chipSel = cs;
    writeEn = we;
    byteSel = bs;
    addr    = a;
    outEn   = oe;
    dataIn  = (p2v && p2w) ? p2d : (36'h3_6C9B_2E51 ^ 36'(checks));
    #1;
    expRd = p2v && !p2w;
    check("R9 rdValid", {35'd0, rdValid}, {35'd0, expRd});
    check("R7/R8 dataOe", {35'd0, dataOe}, {35'd0, expRd && oe});
    if (expRd && oe) check("R2/R5 read data", dataOut, p2d);
    nv = &cs;
    nd = '0;
    if (en && nv) begin
      if (we) begin
        for (int i = 0; i < 4; i++)
          if (bs[i]) refMem[a][i*9 +: 9] = wd[i*9 +: 9];
        nd = wd;
      end else begin
        nd = refMem[a];
      end
    end
    @(posedge clk);
    if (en) begin
      p2v = p1v; p2w = p1w; p2d = p1d;
      p1v = nv;  p1w = we;  p1d = nd;
    end
    @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cyc(1'b1, 3'b000, 1'b0, 4'h0, 8'h0, 36'h0, 1'b1);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = '0;
    p1v = 0; p1w = 0; p2v = 0; p2w = 0; p1d = '0; p2d = '0;
    rstN = 0; clkEn = 1; chipSel = 3'b111; writeEn = 0; byteSel = 4'hF;
    addr = 0; dataIn = '0; outEn = 1;
    repeat (3) @(negedge clk);
    // R1: reset state, even with a read command held on the inputs
    check("R1 rdValid in reset", {35'd0, rdValid}, 36'd0);
    check("R1 dataOe in reset", {35'd0, dataOe}, 36'd0);
    rstN = 1;
    chipSel = 3'b000;
    @(negedge clk);
    check("R1 rdValid after reset", {35'd0, rdValid}, 36'd0);

    // R3: fill every address with full-mask writes, back to back
    for (int a = 0; a < 256; a++) cyc(1'b1, 3'b111, 1'b1, 4'hF, 8'(a), patt(a, 1), 1'b1);
    // R2: read every address back
    for (int a = 0; a < 256; a++) cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b1);
    flush();

    // R5/R3: write then immediately read the same word, every mask
    for (int a = 0; a < 32; a++)
      for (int m = 0; m < 16; m++) begin
        cyc(1'b1, 3'b111, 1'b1, 4'(m), 8'(a), patt(a, m + 7), 1'b1);
        cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b1);
      end
    // R5: write, read elsewhere, read back (gap of one)
    for (int a = 0; a < 32; a++) begin
      cyc(1'b1, 3'b111, 1'b1, 4'(a), 8'(a + 64), patt(a, 99), 1'b1);
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a + 128), 36'h0, 1'b1);
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a + 64), 36'h0, 1'b1);
    end
    flush();

    // R4: every partial chip-select code attempts a write and a read
    for (int c = 0; c < 7; c++) begin
      cyc(1'b1, 3'(c), 1'b1, 4'hF, 8'd5, ~refMem[5], 1'b1);
      cyc(1'b1, 3'(c), 1'b0, 4'h0, 8'd5, 36'h0, 1'b1);
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'd5, 36'h0, 1'b1);
    end
    flush();

    // R8: read slots with output enable low, then high
    for (int a = 0; a < 16; a++) begin
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b0);
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b0);
      cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b1);
    end
    flush();

    // R6/R5/R7: random mix with stalled edges, focused on 8 addresses
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], (lfsr[2] & lfsr[3] & lfsr[4]) ? 3'b110 : 3'b111,
          lfsr[5], lfsr[9:6], {5'd0, lfsr[12:10]}, patt(n, 333), lfsr[15] | lfsr[14]);
    end
    flush();
    for (int a = 0; a < 8; a++) cyc(1'b1, 3'b111, 1'b0, 4'h0, 8'(a), 36'h0, 1'b1);
    flush();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule